// File: doc/BRIEF.md
# Video Sync and Blanking Generator

This block derives all horizontal and vertical timing for a monochrome video camera from a master clock running at a fixed multiple of the line rate. A pixel-clock counter runs inside each line and a line counter runs inside each frame or field. Vertical positions are decoded from these two counters in half-line units. The same counter pair therefore serves the 525-line and 625-line standards, interlaced and progressive scanning, and the field identity flag.

The outputs are horizontal drive, vertical drive, composite sync, composite blanking and an odd-field flag. All of them are active high and leave the block through one register stage. Composite sync follows horizontal drive on ordinary lines. In the vertical sync region it switches to narrow equalizing pulses and broad serrated pulses, both at half-line spacing. The mode inputs are sampled continuously. A change of field length takes effect at the next line boundary.

Top module: `video_timing_gen`

## Requirements
- R1: A line lasts LINE_CLKS master clocks (606 by default). Its second half starts at clock LINE_CLKS/2. Rising edges of `hdrive` are exactly LINE_CLKS clocks apart.
- R2: `hdrive` is high for the first HS_W clocks of every line (45 by default), where clock 0 is the leading edge of horizontal sync.
- R3: `cblank` is the OR of two terms. Horizontal blanking covers the last FRONT clocks of a line (14) plus the first HBLANK-FRONT clocks, with HBLANK = 104 for the 525-line standard and 114 for the 625-line standard. Vertical blanking covers the first 40 half-lines (525) or 50 half-lines (625) of a field.
- R4: `vdrive` is high for the first 18 half-lines (525) or 15 half-lines (625) of each field.
- R5: Outside the `vdrive` region, `csync` equals `hdrive`.
- R6: Equalizing pulses fill the first third and the last third of the vertical sync region (6 half-lines each for 525, 5 each for 625). There, `csync` is high for the first EQ_W clocks (22) of every half-line.
- R7: In the middle third (serration), `csync` is high for the first LINE_CLKS/2 − HS_W clocks of every half-line.
- R8: Interlace (`non_interlace`=0) behaves as follows:
  - The frame has 525 lines (`std_625`=0) or 625 lines (`std_625`=1).
  - The odd field is the first 525 or 625 half-lines of the frame. The even field starts at the middle of line 262 or 312.
  - `field_odd` is high in the odd field and low in the even field.
- R9: Non-interlace (`non_interlace`=1) behaves as follows:
  - Every field has 262 lines (525 standard) or 312 lines (625 standard) when `long_field`=0.
  - It has 263 or 313 lines when `long_field`=1.
  - `field_odd` stays high.
- R10: While `rst_n` is low at a clock edge, all outputs go low and both counters return to line 0, clock 0. After release, the outputs for counter position k appear after the (k+1)-th clock edge.
- R11: If a mode change makes the field limit smaller than the current line number, the line counter returns to 0 at the next line end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, LINE_CLKS per line |
| rst_n | input | 1 | Synchronous active-low reset |
| std_625 | input | 1 | 0: 525-line standard, 1: 625-line standard |
| non_interlace | input | 1 | 1: progressive fields, 0: interlaced frame |
| long_field | input | 1 | In non-interlace, 1 selects the longer field |
| hdrive | output | 1 | Horizontal drive |
| vdrive | output | 1 | Vertical drive |
| csync | output | 1 | Composite sync |
| cblank | output | 1 | Composite blanking |
| field_odd | output | 1 | High during the odd field |

## Verification
The bench samples both thirds of the equalizing zone and the serration zone right at the half-line pulse edges. An off-by-one in pulse width or zone length therefore flips `csync` on exactly one sampled clock. It probes the half-line where the even field begins. A design that split fields on whole lines would keep `field_odd` high and `vdrive` low there. It probes the last line of each field length in both scan modes, so a wrong wrap limit shows up as vertical drive missing or arriving early. It also switches from interlace to non-interlace at line 399, where a counter that wrapped only on equality would run past the new limit and never restart.

// File: rtl/vtg_pkg.sv
// Shared constants and types for the video timing generator.
// Assumes the two line standards use 525 and 625 lines per frame.
package vtg_pkg;
    localparam int LINE_W = 10;          // holds line numbers up to 624
    localparam int HALF_W = LINE_W + 1;  // holds half-line numbers up to 1249

    localparam int FRAME_525   = 525;
    localparam int FRAME_625   = 625;
    localparam int SHORT_525   = 262;
    localparam int SHORT_625   = 312;
    localparam int VS_HALF_525 = 18;
    localparam int VS_HALF_625 = 15;
    localparam int EQ_HALF_525 = 6;
    localparam int EQ_HALF_625 = 5;
    localparam int VB_HALF_525 = 40;
    localparam int VB_HALF_625 = 50;

    typedef struct packed {
        logic hdrive;
        logic vdrive;
        logic csync;
        logic cblank;
        logic field_odd;
    } vtg_out_t;
endpackage

// File: rtl/vtg_hcount.sv
// Pixel-clock counter within a line, plus horizontal decode.
// Clock 0 is the leading edge of horizontal sync. Blanking starts FRONT
// clocks before the end of the line. Assumes FRONT < HBLANK < LINE_CLKS/2.
module vtg_hcount #(
    parameter int LINE_CLKS  = 606,
    parameter int HS_W       = 45,
    parameter int FRONT      = 14,
    parameter int HBLANK_525 = 104,
    parameter int HBLANK_625 = 114,
    parameter int HW         = $clog2(LINE_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          std_625,
    output logic          line_end,
    output logic          second_half,
    output logic [HW-1:0] hpos,
    output logic          hsync,
    output logic          hblank
);
    localparam logic [HW-1:0] LAST_C   = HW'(LINE_CLKS - 1);
    localparam logic [HW-1:0] HALF_C   = HW'(LINE_CLKS / 2);
    localparam logic [HW-1:0] HS_C     = HW'(HS_W);
    localparam logic [HW-1:0] BL_ON_C  = HW'(LINE_CLKS - FRONT);
    localparam logic [HW-1:0] BL_525_C = HW'(HBLANK_525 - FRONT);
    localparam logic [HW-1:0] BL_625_C = HW'(HBLANK_625 - FRONT);

    logic [HW-1:0] hcnt;

    // Advance the clock-in-line counter, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt <= '0;
        else if (hcnt == LAST_C)
            hcnt <= '0;
        else
            hcnt <= hcnt + 1'b1;
    end

    // Decode half-line position, horizontal sync and horizontal blanking.
    always_comb begin
        line_end    = (hcnt == LAST_C);
        second_half = (hcnt >= HALF_C);
        hpos        = second_half ? (hcnt - HALF_C) : hcnt;
        hsync       = (hcnt < HS_C);
        hblank      = (hcnt >= BL_ON_C) ||
                      (hcnt < (std_625 ? BL_625_C : BL_525_C));
    end
endmodule

// File: rtl/vtg_vcount.sv
// Line counter within a frame (interlace) or a field (non-interlace).
// Wraps when a line ends at or beyond the current limit, so a mode change
// that shortens the limit recovers at the next line end.
module vtg_vcount
    import vtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              std_625,
    input  logic              non_interlace,
    input  logic              long_field,
    output logic [LINE_W-1:0] line
);
    logic [LINE_W-1:0] last_line;

    // Select the index of the last line for the current mode.
    always_comb begin
        if (non_interlace)
            last_line = std_625 ? LINE_W'(SHORT_625 - 1 + int'(long_field))
                                : LINE_W'(SHORT_525 - 1 + int'(long_field));
        else
            last_line = std_625 ? LINE_W'(FRAME_625 - 1) : LINE_W'(FRAME_525 - 1);
    end

    // Step the line counter once per line end and return to 0 past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line <= '0;
        else if (line_end)
            line <= (line >= last_line) ? '0 : line + 1'b1;
    end
endmodule

// File: rtl/vtg_vdecode.sv
// Vertical decode in half-line units.
// Forms the field-relative half-line and decodes from it the vertical sync
// zones, vertical blanking, composite sync and the field flag.
// Assumes that hpos counts clocks within the current half-line.
module vtg_vdecode
    import vtg_pkg::*;
#(
    parameter int LINE_CLKS = 606,
    parameter int HS_W      = 45,
    parameter int EQ_W      = 22,
    parameter int HW        = $clog2(LINE_CLKS)
) (
    input  logic              std_625,
    input  logic              non_interlace,
    input  logic [LINE_W-1:0] line,
    input  logic              second_half,
    input  logic [HW-1:0]     hpos,
    input  logic              hsync,
    input  logic              hblank,
    output vtg_out_t          next_out
);
    localparam logic [HW-1:0] EQ_C    = HW'(EQ_W);
    localparam logic [HW-1:0] BROAD_C = HW'(LINE_CLKS / 2 - HS_W);

    logic [HALF_W-1:0] hidx, fh, field_len, vs_len, eq_len, vb_len;
    logic              in_even, in_vs, in_eq;

    // Map the counters to a half-line inside the current field.
    always_comb begin
        field_len = std_625 ? HALF_W'(FRAME_625)   : HALF_W'(FRAME_525);
        vs_len    = std_625 ? HALF_W'(VS_HALF_625) : HALF_W'(VS_HALF_525);
        eq_len    = std_625 ? HALF_W'(EQ_HALF_625) : HALF_W'(EQ_HALF_525);
        vb_len    = std_625 ? HALF_W'(VB_HALF_625) : HALF_W'(VB_HALF_525);
        hidx      = {line, second_half};
        in_even   = !non_interlace && (hidx >= field_len);
        fh        = in_even ? (hidx - field_len) : hidx;
        in_vs     = (fh < vs_len);
        in_eq     = (fh < eq_len) || (fh >= vs_len - eq_len);
    end

    // Compose the next output word from the zone decode.
    always_comb begin
        next_out.hdrive    = hsync;
        next_out.vdrive    = in_vs;
        next_out.cblank    = hblank || (fh < vb_len);
        next_out.field_odd = !in_even;
        if (!in_vs)
            next_out.csync = hsync;
        else if (in_eq)
            next_out.csync = (hpos < EQ_C);
        else
            next_out.csync = (hpos < BROAD_C);
    end
endmodule

// File: rtl/video_timing_gen.sv
// Top of the video sync and blanking generator.
// Chains the horizontal counter, the line counter and the vertical decode,
// then registers all outputs together. Outputs lag the counters by one clock.
module video_timing_gen
    import vtg_pkg::*;
#(
    parameter int LINE_CLKS  = 606,
    parameter int HS_W       = 45,
    parameter int EQ_W       = 22,
    parameter int FRONT      = 14,
    parameter int HBLANK_525 = 104,
    parameter int HBLANK_625 = 114
) (
    input  logic clk,
    input  logic rst_n,
    input  logic std_625,
    input  logic non_interlace,
    input  logic long_field,
    output logic hdrive,
    output logic vdrive,
    output logic csync,
    output logic cblank,
    output logic field_odd
);
    localparam int HW = $clog2(LINE_CLKS);

    logic              line_end, second_half, hsync, hblank;
    logic [HW-1:0]     hpos;
    logic [LINE_W-1:0] line;
    vtg_out_t          next_out, out_q;

    vtg_hcount #(
        .LINE_CLKS(LINE_CLKS), .HS_W(HS_W), .FRONT(FRONT),
        .HBLANK_525(HBLANK_525), .HBLANK_625(HBLANK_625), .HW(HW)
    ) u_hcount (
        .clk(clk), .rst_n(rst_n), .std_625(std_625),
        .line_end(line_end), .second_half(second_half), .hpos(hpos),
        .hsync(hsync), .hblank(hblank)
    );

    vtg_vcount u_vcount (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .std_625(std_625),
        .non_interlace(non_interlace), .long_field(long_field), .line(line)
    );

    vtg_vdecode #(
        .LINE_CLKS(LINE_CLKS), .HS_W(HS_W), .EQ_W(EQ_W), .HW(HW)
    ) u_vdecode (
        .std_625(std_625), .non_interlace(non_interlace), .line(line),
        .second_half(second_half), .hpos(hpos), .hsync(hsync),
        .hblank(hblank), .next_out(next_out)
    );

    // Register the decoded outputs; all deasserted in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= next_out;
    end

    assign hdrive    = out_q.hdrive;
    assign vdrive    = out_q.vdrive;
    assign csync     = out_q.csync;
    assign cblank    = out_q.cblank;
    assign field_odd = out_q.field_odd;
endmodule

// File: rtl/video_timing_gen_chk.sv
// Assertion checker for video_timing_gen, attached by bind.
// Measures the hdrive period with its own counter instead of a deep $past.
module video_timing_gen_chk #(
    parameter int LINE_CLKS = 606
) (
    input logic clk,
    input logic rst_n,
    input logic non_interlace,
    input logic hdrive,
    input logic vdrive,
    input logic csync,
    input logic cblank,
    input logic field_odd
);
    localparam int              GW      = $clog2(LINE_CLKS) + 2;
    localparam logic [GW-1:0]   GAP_EXP = GW'(LINE_CLKS - 1);
    localparam logic [GW-1:0]   GAP_MAX = '1;

    logic [GW-1:0] gap;
    logic          hd_q, seen;

    // Track the clocks elapsed since the last hdrive rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            hd_q <= 1'b0;
            seen <= 1'b0;
        end else begin
            hd_q <= hdrive;
            if (hdrive && !hd_q) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != GAP_MAX) begin
                gap <= gap + 1'b1;
            end
        end
    end

    a_r1_line_period: assert property (@(posedge clk) disable iff (!rst_n)
        (hdrive && !hd_q && seen) |-> (gap == GAP_EXP));

    a_r3_hd_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        hdrive |-> cblank);

    a_r4_vd_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        vdrive |-> cblank);

    a_r5_csync_follows_hd: assert property (@(posedge clk) disable iff (!rst_n)
        !vdrive |-> (csync == hdrive));

    a_r9_progressive_odd: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(non_interlace)) |-> field_odd);

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hdrive && !vdrive && !csync && !cblank && !field_odd));
endmodule

bind video_timing_gen video_timing_gen_chk #(.LINE_CLKS(LINE_CLKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .non_interlace(non_interlace),
    .hdrive(hdrive), .vdrive(vdrive), .csync(csync), .cblank(cblank),
    .field_odd(field_odd)
);

// File: tb/video_timing_gen_bench.sv
`timescale 1ns/1ps
// Bench for video_timing_gen with a 16-clock line so that whole frames fit
// in the run. Each table row resets the block, sets a mode, runs to a
// counter position and compares the output word {hd,vd,cs,cb,fo}.
module video_timing_gen_bench;
    localparam int LINE = 16;   // half-line = 8, broad pulse = 6
    localparam int WD   = 150000;

    typedef struct packed {
        logic       s625;
        logic       nil;
        logic       lng;
        logic [9:0] ln;
        logic [4:0] h;
        logic [4:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,10'd0,  5'd0, 5'b11111,4'd10}, // R10 R6 first position
        '{1'b0,1'b0,1'b0,10'd0,  5'd1, 5'b11011,4'd6},  // R6 eq pulse ends
        '{1'b0,1'b0,1'b0,10'd0,  5'd2, 5'b01011,4'd2},  // R2 hdrive ends
        '{1'b0,1'b0,1'b0,10'd3,  5'd2, 5'b01111,4'd7},  // R7 broad pulse
        '{1'b0,1'b0,1'b0,10'd3,  5'd6, 5'b01011,4'd7},  // R7 serration gap
        '{1'b0,1'b0,1'b0,10'd7,  5'd8, 5'b01111,4'd6},  // R6 post equalizing
        '{1'b0,1'b0,1'b0,10'd7,  5'd9, 5'b01011,4'd6},  // R6 post eq width
        '{1'b0,1'b0,1'b0,10'd9,  5'd0, 5'b10111,4'd4},  // R4 vdrive over, R5
        '{1'b0,1'b0,1'b0,10'd20, 5'd5, 5'b00001,4'd3},  // R3 active video
        '{1'b0,1'b0,1'b0,10'd20, 5'd15,5'b00011,4'd3},  // R3 front porch
        '{1'b0,1'b0,1'b0,10'd262,5'd0, 5'b10111,4'd8},  // R8 odd field tail
        '{1'b0,1'b0,1'b0,10'd262,5'd8, 5'b01110,4'd8},  // R8 even starts mid-line
        '{1'b0,1'b0,1'b0,10'd525,5'd0, 5'b11111,4'd8},  // R8 frame wrap 525
        '{1'b1,1'b0,1'b0,10'd2,  5'd8, 5'b01111,4'd7},  // R7 625 serration
        '{1'b1,1'b0,1'b0,10'd7,  5'd8, 5'b00011,4'd4},  // R4 625 vdrive length
        '{1'b1,1'b0,1'b0,10'd25, 5'd2, 5'b00011,4'd3},  // R3 625 blank widths
        '{1'b1,1'b0,1'b0,10'd312,5'd8, 5'b01110,4'd8},  // R8 625 even field
        '{1'b0,1'b1,1'b0,10'd262,5'd0, 5'b11111,4'd9},  // R9 262-line wrap
        '{1'b0,1'b1,1'b1,10'd262,5'd0, 5'b10111,4'd9},  // R9 263 still running
        '{1'b0,1'b1,1'b1,10'd263,5'd0, 5'b11111,4'd9},  // R9 263-line wrap
        '{1'b0,1'b1,1'b0,10'd131,5'd8, 5'b00001,4'd9},  // R9 no even field
        '{1'b1,1'b1,1'b1,10'd312,5'd0, 5'b10111,4'd9}   // R9 313 still running
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic std_625 = 1'b0, non_interlace = 1'b0, long_field = 1'b0;
    logic hdrive, vdrive, csync, cblank, field_odd;
    int   tests = 0, fails = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    video_timing_gen #(
        .LINE_CLKS(LINE), .HS_W(2), .EQ_W(1), .FRONT(1),
        .HBLANK_525(3), .HBLANK_625(4)
    ) u_video_timing_gen (
        .clk(clk), .rst_n(rst_n), .std_625(std_625),
        .non_interlace(non_interlace), .long_field(long_field),
        .hdrive(hdrive), .vdrive(vdrive), .csync(csync), .cblank(cblank),
        .field_odd(field_odd)
    );

    task automatic check(input int req, input logic [4:0] exp, input string what);
        logic [4:0] act;
        act = {hdrive, vdrive, csync, cblank, field_odd};
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic start(input logic s, input logic n, input logic l);
        @(negedge clk);
        std_625 = s; non_interlace = n; long_field = l; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R10: outputs low while reset is held
        repeat (2) @(negedge clk);
        check(10, 5'b00000, "reset state");

        for (int i = 0; i < NV; i++) begin
            start(VECS[i].s625, VECS[i].nil, VECS[i].lng);
            repeat (int'(VECS[i].ln) * LINE + int'(VECS[i].h) + 1) @(posedge clk);
            @(negedge clk);
            check(int'(VECS[i].req), VECS[i].exp, $sformatf("vec %0d", i));
        end

        // R11: switch to a 262-line field while on line 399
        start(1'b0, 1'b0, 1'b0);
        repeat (399 * LINE + 5) @(posedge clk);
        @(negedge clk);
        non_interlace = 1'b1;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(11, 5'b11111, "shrink wrap to line 0");

        // R10: reset in mid-run clears outputs on the next edge
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(10, 5'b00000, "mid-run reset");
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule